// File: doc/BRIEF.md
# Learning Bridge Forwarding Decision

This block makes the forwarding decision for a transparent layer-2 bridge. Each received frame is presented as a request carrying its 48-bit source MAC, its 48-bit destination MAC and the number of the port it arrived on. The block answers with an egress port mask, where bit p of the mask stands for port p.

The result is one of three cases. The mask can hold a single port. It can flood to every port except the ingress port. It can also be empty, which filters the frame. On the same frame, the source address is learned against the ingress port in a small fully associative address table, and each table entry has its own valid bit.

Only one decision is in progress at a time. A request is accepted when the block is idle. While the decision is pending, `busy` is high and any new request is dropped. The mask appears with a one-cycle `res_valid` strobe a fixed two clock edges after acceptance. A `flush` input empties the whole table in one cycle.

Top module: `l2_learn_fwd`

## Requirements
- R1: A request presented while `busy` is low is accepted at that clock edge. `busy` is then high for exactly one cycle, and `res_valid` is high for exactly the one cycle after that, together with the result mask.
- R2: A request presented while `busy` is high is ignored. It produces no result and teaches the table nothing.
- R3: If bit 47 of the destination is 1 (a group address), the mask holds every port except the ingress port, whatever the table holds.
- R4: If the destination is a unicast address (bit 47 = 0) and is not in the table, the mask holds every port except the ingress port.
- R5: If the destination is in the table with the same port as the ingress port, the mask is all zeros.
- R6: If the destination is in the table with a different port, the mask holds only that port's bit.
- R7: A source address that is not in the table is stored with its ingress port. Later frames addressed to it then go to that port alone.
- R8: A source address already in the table that arrives on a different port has its stored port overwritten with the new port.
- R9: The destination lookup sees the table as it was before the current frame's own learning. A frame whose source equals its destination, with that address not yet known, is flooded.
- R10: A new address goes into the lowest-numbered free entry. When no entry is free, entries are overwritten in round-robin order starting at entry 0 after reset.
- R11: A `flush` pulse makes all entries invalid in one cycle. If a flush and a learning write fall in the same cycle, the flush wins.
- R12: After reset `busy` and `res_valid` are low, and `res_mask` is all zeros whenever `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every table entry |
| req_valid | input | 1 | Frame decision request |
| req_sa | input | 48 | Source MAC address |
| req_da | input | 48 | Destination MAC address (bit 47 = group) |
| req_port | input | 2 | Ingress port number |
| busy | output | 1 | Decision pending; requests are ignored |
| res_valid | output | 1 | Result strobe |
| res_mask | output | 4 | Egress port mask, bit p = port p |

## Verification
A wrong table state cannot be seen until a later frame names the damaged address as its destination. A lost or stale entry then shows as a flood where a single port or an empty mask was due. A wrong stored port shows as the wrong single bit. Either error appears on the `res_valid` strobe of that later frame, two edges after it is accepted. Flaws in replacement order and flush only appear once the table has filled or been cleared, so the scenarios are built to fill and clear it on purpose before probing individual addresses.

// File: rtl/l2_learn_fwd.sv
module l2_learn_fwd #(
  parameter int NPORTS  = 4,
  parameter int ENTRIES = 8,
  parameter int AW      = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_sa,
  input  logic [AW-1:0]     req_da,
  input  logic [$clog2(NPORTS)-1:0] req_port,
  output logic              busy,
  output logic              res_valid,
  output logic [NPORTS-1:0] res_mask
);
  localparam int PW = $clog2(NPORTS);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [AW-1:0]     tab_mac  [ENTRIES];
  logic [PW-1:0]     tab_port [ENTRIES];
  logic [ENTRIES-1:0] tab_vld;

  logic              pend;
  logic [AW-1:0]     p_sa, p_da;
  logic [PW-1:0]     p_port;
  logic [IW-1:0]     victim;

  logic [ENTRIES-1:0] sa_hit, da_hit;
  logic [IW-1:0]     sa_idx, free_idx, wr_idx;
  logic [PW-1:0]     da_port;
  logic              have_free, learn;
  logic [NPORTS-1:0] others, decision;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign sa_hit[i] = tab_vld[i] && (tab_mac[i] == p_sa);
    assign da_hit[i] = tab_vld[i] && (tab_mac[i] == p_da);
  end

  always_comb begin
    sa_idx    = '0;
    free_idx  = '0;
    da_port   = '0;
    have_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (sa_hit[i]) sa_idx = IW'(i);
      if (!tab_vld[i]) begin
        free_idx  = IW'(i);
        have_free = 1'b1;
      end
    end
    for (int i = 0; i < ENTRIES; i++)
      if (da_hit[i]) da_port = da_port | tab_port[i];
  end

  assign others = {NPORTS{1'b1}} & ~(NPORTS'(1) << p_port);

  always_comb begin
    if (p_da[AW-1] || !(|da_hit)) decision = others;
    else if (da_port == p_port)   decision = '0;
    else                          decision = NPORTS'(1) << da_port;
  end

  assign learn  = pend && !flush;
  assign wr_idx = (|sa_hit) ? sa_idx : (have_free ? free_idx : victim);
  assign busy   = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      res_valid <= 1'b0;
      res_mask  <= '0;
      tab_vld   <= '0;
      victim    <= '0;
    end else begin
      pend      <= req_valid && !pend;
      res_valid <= pend;
      res_mask  <= pend ? decision : '0;
      if (flush) tab_vld <= '0;
      else if (learn) tab_vld[wr_idx] <= 1'b1;
      if (learn && !(|sa_hit) && !have_free)
        victim <= (victim == IW'(ENTRIES - 1)) ? '0 : victim + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid && !pend) begin
      p_sa   <= req_sa;
      p_da   <= req_da;
      p_port <= req_port;
    end
    if (learn) begin
      tab_mac[wr_idx]  <= p_sa;
      tab_port[wr_idx] <= p_port;
    end
  end
endmodule

module l2_learn_fwd_chk #(
  parameter int NPORTS  = 4,
  parameter int ENTRIES = 8,
  parameter int AW      = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              req_valid,
  input logic [AW-1:0]     req_da,
  input logic [$clog2(NPORTS)-1:0] req_port,
  input logic              busy,
  input logic              res_valid,
  input logic [NPORTS-1:0] res_mask,
  input logic [ENTRIES-1:0] tab_vld
);
  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
  assert_one_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy && res_valid));
  assert_strobe_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(busy));
  assert_no_ingress_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !res_mask[$past(req_port, 2)]);
  assert_group_flood_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(req_da[AW-1], 2)) |->
      ($countones(res_mask) == NPORTS - 1));
  assert_idle_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_mask == '0));
  assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tab_vld == '0));
endmodule

bind l2_learn_fwd l2_learn_fwd_chk #(.NPORTS(NPORTS), .ENTRIES(ENTRIES), .AW(AW)) u_chk (.*);

// File: tb/sim_l2_learn_fwd.sv
module sim_l2_learn_fwd;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, flush, req_valid;
  logic [47:0] req_sa, req_da;
  logic [1:0]  req_port;
  logic        busy, res_valid;
  logic [3:0]  res_mask;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2_learn_fwd u0 (.clk, .rst_n, .flush, .req_valid, .req_sa, .req_da,
                   .req_port, .busy, .res_valid, .res_mask);

  function automatic logic [47:0] uc(input int n);
    return 48'h0200_0000_0000 + 48'(n);
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [47:0] sa, input logic [47:0] da,
                       input logic [1:0] pt, input logic [3:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_sa = sa; req_da = da; req_port = pt;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(tag, {res_valid, res_mask}, {1'b1, exp});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0;
    req_sa = '0; req_da = '0; req_port = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset", {busy, res_valid, res_mask[2:0]}, 5'b0);
  endtask

  task automatic t_basic;
    frame(uc(1), 48'h8000_0000_0001, 2'd1, 4'b1101, "R3 group da");
    frame(uc(2), uc(3), 2'd2, 4'b1011, "R4 unknown da");
    frame(uc(3), uc(1), 2'd3, 4'b0010, "R6 R7 known da");
    frame(uc(4), uc(1), 2'd1, 4'b0000, "R5 same port filter");
    frame(uc(3), 48'hFFFF_FFFF_FFFF, 2'd3, 4'b0111, "R3 broadcast known sa");
  endtask

  task automatic t_move;
    frame(uc(1), uc(2), 2'd0, 4'b0100, "R8 move frame");
    frame(uc(2), uc(1), 2'd2, 4'b0001, "R8 moved port");
  endtask

  task automatic t_same_frame;
    frame(uc(6), uc(6), 2'd2, 4'b1011, "R9 sa equals da");
    frame(uc(7), uc(6), 2'd0, 4'b0100, "R9 learned after");
  endtask

  task automatic t_busy;
    @(negedge clk);
    req_valid = 1'b1; req_sa = uc(8); req_da = uc(1); req_port = 2'd1;
    @(negedge clk);
    chk("R1 busy high", {4'b0, busy}, 5'b1);
    req_sa = uc(9); req_da = uc(2); req_port = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 result", {res_valid, res_mask}, 5'b10001);
    chk("R1 busy low", {4'b0, busy}, 5'b0);
    @(negedge clk);
    chk("R2 no second result", {4'b0, res_valid}, 5'b0);
    frame(uc(10), uc(9), 2'd0, 4'b1110, "R2 rejected sa not learned");
  endtask

  task automatic t_flush;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    frame(uc(11), uc(1), 2'd3, 4'b0111, "R11 flush forgets");
    @(negedge clk);
    req_valid = 1'b1; req_sa = uc(12); req_da = uc(99); req_port = 2'd2;
    @(negedge clk);
    req_valid = 1'b0; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk("R11 result during flush", {res_valid, res_mask}, 5'b11011);
    frame(uc(13), uc(12), 2'd0, 4'b1110, "R11 flush beats learn");
  endtask

  task automatic t_replace;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int i = 0; i < 8; i++)
      frame(uc(20 + i), 48'h8000_0000_0000, 2'd1, 4'b1101, "R10 fill");
    frame(uc(28), 48'h8000_0000_0000, 2'd2, 4'b1011, "R10 ninth");
    frame(uc(28), uc(20), 2'd2, 4'b1011, "R10 entry0 replaced");
    frame(uc(28), uc(21), 2'd2, 4'b0010, "R10 entry1 kept");
    frame(uc(28), uc(28), 2'd2, 4'b0000, "R10 new entry");
    frame(uc(29), uc(21), 2'd3, 4'b0010, "R10 tenth");
    frame(uc(28), uc(21), 2'd2, 4'b1011, "R10 round robin");
    frame(uc(28), uc(22), 2'd2, 4'b0010, "R10 entry2 kept");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset;
    t_basic;
    t_move;
    t_same_frame;
    t_busy;
    t_flush;
    t_replace;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule